// File: doc/BRIEF.md
# UART Host Register Write Path

This block is the host-facing write side of a 16550-compatible serial port register file. A host presents a 3-bit register offset, a byte of data and a one-cycle write strobe. The block decodes the offset, stores the interrupt-enable, line-control, modem-control, FIFO-control and scratch registers and the 16-bit baud divisor. It also turns data-register writes into one-cycle strobes for the rest of the UART. In normal mode such a write strobes the transmitter. In loopback mode it pushes the byte into the receive FIFO, and when that FIFO is full it records an overrun instead.

A combinational read port returns the stored values, so the host can check each write. When bit 7 of the line-control register is set, offsets 0 and 1 reach the two divisor bytes in place of the data and interrupt-enable registers. A write to the FIFO-control register that flips the FIFO enable requests a receive FIFO reset and announces the new depth. A write with the receiver-flush bit set also requests a reset.

All effects of a write appear on the outputs in the cycle after the clock edge that samples the strobe. The serializer, the baud counter, the FIFO storage and the interrupt priority logic sit outside this block and use its outputs.

Top module: `uart_regwr`

## Requirements
- R1: While line-control bit 7 is 1, a write to offset 0 loads divisor bits 7:0 and a write to offset 1 loads divisor bits 15:8. Both bytes read back at offsets 0 and 1. Such a write leaves the interrupt-enable register unchanged and raises no transmit strobe, no loopback push and no pending flag.
- R2: A write to offset 1 (bank bit clear) keeps data bits 3:0 as the interrupt-enable value. A read of offset 1 returns those bits with bits 7:4 zero.
- R3: A write to offset 4 keeps data bits 4:0 as the modem-control value. A read of offset 4 returns bits 7:5 as zero. Bit 4 of this register is the loopback mode.
- R4: A write to offset 2 whose bit 0 differs from the stored FIFO-enable bit pulses `fifo_rst` for one cycle after the write. `fifo_deep` then equals the new bit 0: 1 for the full FIFO, 0 for one entry.
- R5: A write to offset 2 with bit 0 clear stores zero. With bit 0 set it stores the data ANDed with 0xC9, keeping enable (bit 0), DMA mode (bit 3) and receive trigger (bits 7:6). Offset 2 reads back the stored value.
- R6: A write to offset 2 with bits 0 and 1 both set pulses `fifo_rst`, even when the enable bit does not change.
- R7: In loopback mode a data write (offset 0, bank bit clear) with `rx_full` low pulses `lb_push` with the byte on `byte_out` and does not strobe the transmitter. With `rx_full` high there is no push and the overrun flag is set. The flag reads as bit 1 of offset 5, and a read of offset 5 with `rd_en` high clears it.
- R8: Outside loopback mode a data write pulses `tx_strobe` with the byte on `byte_out`. Every data write sets `thre_pend`. `thre_ack` clears `thre_pend`, and a set in the same cycle takes priority.
- R9: Writes to offsets 5 and 6 change no stored value and no output. Offset 6 reads zero. Offset 7 stores and returns any byte.
- R10: After reset the divisor equals CLK_HZ/(16*BAUD). All other registers are zero, `fifo_deep` is 0 (one-entry mode) and no strobe or flag is active.
- R11: A write to offset 3 stores the full byte as line control. The register reads back at offset 3 and drives `line_ctrl`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 3 | Write register offset |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe; used to clear the overrun flag on an offset-5 read |
| rd_addr | input | 3 | Read register offset |
| rd_data | output | 8 | Read data (combinational) |
| rx_full | input | 1 | Receive FIFO is full |
| thre_ack | input | 1 | Interrupt logic acknowledges the pending transmit flag |
| byte_out | output | 8 | Byte of the last data write |
| lb_push | output | 1 | Push `byte_out` into the receive FIFO |
| tx_strobe | output | 1 | Hand `byte_out` to the transmitter |
| fifo_rst | output | 1 | Receive FIFO reset request |
| fifo_deep | output | 1 | 1: full FIFO depth, 0: single entry |
| thre_pend | output | 1 | Transmit-holding-empty interrupt pending |
| divisor | output | 16 | Baud divisor |
| line_ctrl | output | 8 | Line control value |
| irq_en | output | 4 | Interrupt enables |
| modem_ctrl | output | 5 | Modem control value |

## Verification
A wrong bank decode shows up on the next cycle in one of two ways. Either a divisor write also strobes the transmitter, or the interrupt enables change when they should not. The bench also sees it on the `divisor` output one cycle after the write. A FIFO-control register holding a stale enable bit shows up at the next FIFO-control write: the `fifo_rst` pulse is missing or extra, and the readback value is wrong. A lost overrun or pending flag is visible at once on `thre_pend` or at the next offset-5 read. Each write is therefore checked on its strobes one cycle later, and the full readback is compared against a model at regular intervals.

// File: rtl/uart_wr_pkg.sv
package uart_wr_pkg;

    localparam int BYTE_W  = 8;
    localparam int IER_W   = 4;
    localparam int MCR_W   = 5;
    localparam int DIV_W   = 16;

    localparam int BANK_BIT   = 7;  // line control: divisor bank select
    localparam int LOOP_BIT   = 4;  // modem control: loopback
    localparam int FEN_BIT    = 0;  // fifo control: enable
    localparam int FFLUSH_BIT = 1;  // fifo control: receiver flush
    localparam int OVR_BIT    = 1;  // line status: overrun

    localparam logic [BYTE_W-1:0] FCR_KEEP = 8'hC9;

    typedef enum logic [2:0] {
        OFS_DATA = 3'd0,
        OFS_IEN  = 3'd1,
        OFS_FCTL = 3'd2,
        OFS_LCTL = 3'd3,
        OFS_MCTL = 3'd4,
        OFS_LSTA = 3'd5,
        OFS_MSTA = 3'd6,
        OFS_SCR  = 3'd7
    } ofs_e;

    typedef struct packed {
        logic div_lo;
        logic div_hi;
        logic data;
        logic ien;
        logic fctl;
        logic lctl;
        logic mctl;
        logic scr;
    } wsel_t;

    function automatic logic [BYTE_W-1:0] fctl_next(input logic [BYTE_W-1:0] v);
        return v[FEN_BIT] ? (v & FCR_KEEP) : '0;
    endfunction

    function automatic logic [DIV_W-1:0] div_init(input int clk_hz, input int baud);
        return DIV_W'(clk_hz / (16 * baud));
    endfunction

endpackage

// File: rtl/uart_wr_decode.sv
module uart_wr_decode
    import uart_wr_pkg::*;
(
    input  logic       wr_en,
    input  logic [2:0] wr_addr,
    input  logic       bank,
    output wsel_t      sel
);
    always_comb begin
        sel = '0;
        if (wr_en) begin
            unique case (ofs_e'(wr_addr))
                OFS_DATA: if (bank) sel.div_lo = 1'b1; else sel.data = 1'b1;
                OFS_IEN:  if (bank) sel.div_hi = 1'b1; else sel.ien  = 1'b1;
                OFS_FCTL: sel.fctl = 1'b1;
                OFS_LCTL: sel.lctl = 1'b1;
                OFS_MCTL: sel.mctl = 1'b1;
                OFS_SCR:  sel.scr  = 1'b1;
                default:  ;  // status offsets: writes dropped
            endcase
        end
    end
endmodule

// File: rtl/uart_wr_regs.sv
module uart_wr_regs
    import uart_wr_pkg::*;
#(
    parameter logic [DIV_W-1:0] DIV_RESET = 16'd27
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we_lo,
    input  logic              we_hi,
    input  logic              we_ien,
    input  logic              we_lctl,
    input  logic              we_mctl,
    input  logic              we_scr,
    input  logic [BYTE_W-1:0] din,
    output logic [IER_W-1:0]  ien_q,
    output logic [BYTE_W-1:0] lctl_q,
    output logic [MCR_W-1:0]  mctl_q,
    output logic [BYTE_W-1:0] scr_q,
    output logic [DIV_W-1:0]  div_q
);
    localparam int DIV_BYTES = DIV_W / BYTE_W;

    logic [DIV_BYTES-1:0] div_we;
    assign div_we = {we_hi, we_lo};

    for (genvar b = 0; b < DIV_BYTES; b++) begin : g_div
        always_ff @(posedge clk) begin
            if (rst)            div_q[b*BYTE_W +: BYTE_W] <= DIV_RESET[b*BYTE_W +: BYTE_W];
            else if (div_we[b]) div_q[b*BYTE_W +: BYTE_W] <= din;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ien_q  <= '0;
            lctl_q <= '0;
            mctl_q <= '0;
            scr_q  <= '0;
        end else begin
            if (we_ien)  ien_q  <= din[IER_W-1:0];
            if (we_lctl) lctl_q <= din;
            if (we_mctl) mctl_q <= din[MCR_W-1:0];
            if (we_scr)  scr_q  <= din;
        end
    end

    a_r11_lctl_load: assert property (@(posedge clk) disable iff (rst)
        we_lctl |=> (lctl_q == $past(din)));
    a_r2_ien_hold: assert property (@(posedge clk) disable iff (rst)
        !we_ien |=> $stable(ien_q));
endmodule

// File: rtl/uart_wr_fifoctl.sv
module uart_wr_fifoctl
    import uart_wr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we_fctl,
    input  logic [BYTE_W-1:0] din,
    output logic [BYTE_W-1:0] fctl_q,
    output logic              fifo_rst,
    output logic              fifo_deep
);
    logic mode_flip, flush_req;

    assign mode_flip = din[FEN_BIT] ^ fctl_q[FEN_BIT];
    assign flush_req = din[FEN_BIT] & din[FFLUSH_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            fctl_q    <= '0;
            fifo_rst  <= 1'b0;
            fifo_deep <= 1'b0;
        end else begin
            fifo_rst <= we_fctl & (mode_flip | flush_req);
            if (we_fctl) begin
                fctl_q    <= fctl_next(din);
                fifo_deep <= din[FEN_BIT];
            end
        end
    end

    a_r4_flip_resets: assert property (@(posedge clk) disable iff (rst)
        (we_fctl && (din[FEN_BIT] != fctl_q[FEN_BIT]))
        |=> (fifo_rst && (fifo_deep == $past(din[FEN_BIT]))));
    a_r5_off_clears: assert property (@(posedge clk) disable iff (rst)
        (we_fctl && !din[FEN_BIT]) |=> (fctl_q == '0));
    a_r6_flush_resets: assert property (@(posedge clk) disable iff (rst)
        (we_fctl && din[FEN_BIT] && din[FFLUSH_BIT]) |=> fifo_rst);
endmodule

// File: rtl/uart_wr_txpath.sv
module uart_wr_txpath
    import uart_wr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we_data,
    input  logic              loop,
    input  logic [BYTE_W-1:0] din,
    input  logic              rx_full,
    input  logic              thre_ack,
    input  logic              sta_rd,
    output logic [BYTE_W-1:0] byte_out,
    output logic              lb_push,
    output logic              tx_strobe,
    output logic              thre_pend,
    output logic              overrun
);
    logic lost;
    assign lost = we_data & loop & rx_full;

    always_ff @(posedge clk) begin
        if (rst) begin
            byte_out  <= '0;
            lb_push   <= 1'b0;
            tx_strobe <= 1'b0;
            thre_pend <= 1'b0;
            overrun   <= 1'b0;
        end else begin
            lb_push   <= we_data & loop & ~rx_full;
            tx_strobe <= we_data & ~loop;
            if (we_data) byte_out <= din;

            if (we_data)       thre_pend <= 1'b1;
            else if (thre_ack) thre_pend <= 1'b0;

            if (lost)        overrun <= 1'b1;
            else if (sta_rd) overrun <= 1'b0;
        end
    end

    a_r7_full_drops: assert property (@(posedge clk) disable iff (rst)
        lost |=> (!lb_push && overrun));
    a_r8_thre_set: assert property (@(posedge clk) disable iff (rst)
        we_data |=> thre_pend);
    a_r8_one_target: assert property (@(posedge clk) disable iff (rst)
        !(lb_push && tx_strobe));
endmodule

// File: rtl/uart_regwr.sv
module uart_regwr
    import uart_wr_pkg::*;
#(
    parameter int CLK_HZ = 50_000_000,
    parameter int BAUD   = 115_200
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [2:0]  wr_addr,
    input  logic [7:0]  wr_data,
    input  logic        rd_en,
    input  logic [2:0]  rd_addr,
    output logic [7:0]  rd_data,
    input  logic        rx_full,
    input  logic        thre_ack,
    output logic [7:0]  byte_out,
    output logic        lb_push,
    output logic        tx_strobe,
    output logic        fifo_rst,
    output logic        fifo_deep,
    output logic        thre_pend,
    output logic [15:0] divisor,
    output logic [7:0]  line_ctrl,
    output logic [3:0]  irq_en,
    output logic [4:0]  modem_ctrl
);
    localparam logic [DIV_W-1:0] DIV_RESET = div_init(CLK_HZ, BAUD);

    wsel_t             sel;
    logic [BYTE_W-1:0] fctl_q, scr_q;
    logic              overrun, sta_rd;

    uart_wr_decode u_dec (
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .bank    (line_ctrl[BANK_BIT]),
        .sel     (sel)
    );

    uart_wr_regs #(.DIV_RESET(DIV_RESET)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .we_lo   (sel.div_lo),
        .we_hi   (sel.div_hi),
        .we_ien  (sel.ien),
        .we_lctl (sel.lctl),
        .we_mctl (sel.mctl),
        .we_scr  (sel.scr),
        .din     (wr_data),
        .ien_q   (irq_en),
        .lctl_q  (line_ctrl),
        .mctl_q  (modem_ctrl),
        .scr_q   (scr_q),
        .div_q   (divisor)
    );

    uart_wr_fifoctl u_fctl (
        .clk       (clk),
        .rst       (rst),
        .we_fctl   (sel.fctl),
        .din       (wr_data),
        .fctl_q    (fctl_q),
        .fifo_rst  (fifo_rst),
        .fifo_deep (fifo_deep)
    );

    assign sta_rd = rd_en & (rd_addr == OFS_LSTA);

    uart_wr_txpath u_tx (
        .clk       (clk),
        .rst       (rst),
        .we_data   (sel.data),
        .loop      (modem_ctrl[LOOP_BIT]),
        .din       (wr_data),
        .rx_full   (rx_full),
        .thre_ack  (thre_ack),
        .sta_rd    (sta_rd),
        .byte_out  (byte_out),
        .lb_push   (lb_push),
        .tx_strobe (tx_strobe),
        .thre_pend (thre_pend),
        .overrun   (overrun)
    );

    always_comb begin
        rd_data = '0;
        unique case (ofs_e'(rd_addr))
            OFS_DATA: if (line_ctrl[BANK_BIT]) rd_data = divisor[BYTE_W-1:0];
            OFS_IEN:  rd_data = line_ctrl[BANK_BIT] ? divisor[DIV_W-1:BYTE_W]
                                                    : {{(BYTE_W-IER_W){1'b0}}, irq_en};
            OFS_FCTL: rd_data = fctl_q;
            OFS_LCTL: rd_data = line_ctrl;
            OFS_MCTL: rd_data = {{(BYTE_W-MCR_W){1'b0}}, modem_ctrl};
            OFS_LSTA: rd_data[OVR_BIT] = overrun;
            OFS_MSTA: rd_data = '0;
            OFS_SCR:  rd_data = scr_q;
            default:  rd_data = '0;
        endcase
    end

    a_r1_bank_blocks_ien: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == 3'd1 && line_ctrl[BANK_BIT])
        |=> ($stable(irq_en) && !tx_strobe && !lb_push));
    a_r9_status_ignored: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (wr_addr == 3'd5 || wr_addr == 3'd6))
        |=> ($stable(line_ctrl) && $stable(divisor) && !fifo_rst && !tx_strobe));
endmodule

// File: tb/uart_regwr_tb_top.sv
module uart_regwr_tb_top;
    localparam int CLK_HZ = 50_000_000;
    localparam int BAUD   = 115_200;
    localparam logic [15:0] DIV0 = 16'(CLK_HZ / (16 * BAUD));

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0, rd_en = 1'b0, rx_full = 1'b0, thre_ack = 1'b0;
    logic [2:0]  wr_addr = '0, rd_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [7:0]  rd_data, byte_out, line_ctrl;
    logic        lb_push, tx_strobe, fifo_rst, fifo_deep, thre_pend;
    logic [15:0] divisor;
    logic [3:0]  irq_en;
    logic [4:0]  modem_ctrl;

    always #2 clk = ~clk;

    uart_regwr #(.CLK_HZ(CLK_HZ), .BAUD(BAUD)) dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .rx_full(rx_full),
        .thre_ack(thre_ack), .byte_out(byte_out), .lb_push(lb_push),
        .tx_strobe(tx_strobe), .fifo_rst(fifo_rst), .fifo_deep(fifo_deep),
        .thre_pend(thre_pend), .divisor(divisor), .line_ctrl(line_ctrl),
        .irq_en(irq_en), .modem_ctrl(modem_ctrl)
    );

    int n_chk = 0, n_bad = 0;

    // reference model
    logic [7:0]  m_ien, m_fctl, m_lctl, m_mctl, m_scr;
    logic [15:0] m_div;
    logic        m_ovr, m_thre;

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_rd(input logic [2:0] o);
        case (o)
            3'd0: return m_lctl[7] ? m_div[7:0] : 8'h00;
            3'd1: return m_lctl[7] ? m_div[15:8] : m_ien;
            3'd2: return m_fctl;
            3'd3: return m_lctl;
            3'd4: return m_mctl;
            3'd5: return {6'b0, m_ovr, 1'b0};
            3'd6: return 8'h00;
            default: return m_scr;
        endcase
    endfunction

    task automatic model_reset();
        m_ien = 0; m_fctl = 0; m_lctl = 0; m_mctl = 0; m_scr = 0;
        m_div = DIV0; m_ovr = 0; m_thre = 0;
    endtask

    // called at a negedge; returns at the next negedge after checking strobes
    task automatic wr(input logic [2:0] a, input logic [7:0] d, input logic full);
        logic e_push, e_tx, e_rst;
        e_push = 0; e_tx = 0; e_rst = 0;
        if (m_lctl[7] && a == 3'd0)      m_div[7:0]  = d;
        else if (m_lctl[7] && a == 3'd1) m_div[15:8] = d;
        else begin
            case (a)
                3'd0: begin
                    if (m_mctl[4]) begin
                        if (!full) e_push = 1; else m_ovr = 1;
                    end else e_tx = 1;
                    m_thre = 1;
                end
                3'd1: m_ien = d & 8'h0F;
                3'd2: begin
                    e_rst = (m_fctl[0] != d[0]) || (d[0] && d[1]);
                    m_fctl = d[0] ? (d & 8'hC9) : 8'h00;
                end
                3'd3: m_lctl = d;
                3'd4: m_mctl = d & 8'h1F;
                3'd7: m_scr = d;
                default: ;
            endcase
        end
        wr_en = 1; wr_addr = a; wr_data = d; rx_full = full;
        @(negedge clk);
        wr_en = 0; rx_full = 0;
        check("R7 lb_push", lb_push, e_push);
        check("R8 tx_strobe", tx_strobe, e_tx);
        if (e_push || e_tx) check("R7/R8 byte_out", byte_out, d);
        check("R4/R6 fifo_rst", fifo_rst, e_rst);
        check("R4 fifo_deep", fifo_deep, m_fctl[0]);
        check("R8 thre_pend", thre_pend, m_thre);
        check("R1 divisor", divisor, m_div);
    endtask

    task automatic check_all(input string tag);
        for (int o = 0; o < 8; o++) begin
            rd_addr = 3'(o);
            #1;
            check({tag, " readback"}, rd_data, exp_rd(3'(o)));
        end
        check("R11 line_ctrl", line_ctrl, m_lctl);
        check("R2 irq_en", irq_en, m_ien[3:0]);
        check("R3 modem_ctrl", modem_ctrl, m_mctl[4:0]);
        check("R1 divisor", divisor, m_div);
        @(negedge clk);
    endtask

    task automatic sta_read();
        rd_en = 1; rd_addr = 3'd5;
        #1 check("R7 overrun read", rd_data, exp_rd(3'd5));
        @(negedge clk);
        rd_en = 0;
        m_ovr = 0;
        #1 check("R7 overrun cleared", rd_data, 8'h00);
    endtask

    task automatic ack();
        thre_ack = 1;
        @(negedge clk);
        thre_ack = 0;
        m_thre = 0;
        check("R8 thre_ack clears", thre_pend, 1'b0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd1729));
        model_reset();
        repeat (3) @(negedge clk);
        rst = 0;
        // R10 reset state
        check("R10 divisor reset", divisor, DIV0);
        check("R10 no push", lb_push, 1'b0);
        check("R10 no tx", tx_strobe, 1'b0);
        check("R10 no fifo_rst", fifo_rst, 1'b0);
        check("R10 fifo_deep", fifo_deep, 1'b0);
        check("R10 thre_pend", thre_pend, 1'b0);
        check_all("R10");

        // R1 divisor banking
        wr(3'd3, 8'h80, 0);
        wr(3'd0, 8'h34, 0);
        wr(3'd1, 8'h12, 0);
        check("R1 divisor loaded", divisor, 16'h1234);
        check_all("R1");
        wr(3'd2, 8'h01, 0);          // fifo control still reachable while banked
        wr(3'd3, 8'h03, 0);
        check_all("R11");

        // R2 / R3 masks
        wr(3'd1, 8'hFF, 0);
        wr(3'd4, 8'hEF, 0);
        check_all("R2/R3");

        // R7 loopback
        wr(3'd4, 8'h10, 0);
        wr(3'd0, 8'h5A, 0);
        wr(3'd0, 8'hA5, 1);
        check_all("R7");
        sta_read();

        // R8 transmit path and acknowledge
        wr(3'd4, 8'h00, 0);
        ack();
        wr(3'd0, 8'h77, 0);
        ack();

        // R4/R5/R6 fifo control
        wr(3'd2, 8'hFF, 0);          // flush with enable held
        check_all("R5");
        wr(3'd2, 8'hC9, 0);          // no change, no flush
        wr(3'd2, 8'hFE, 0);          // disable -> cleared, reset
        check_all("R5");
        wr(3'd2, 8'h00, 0);          // stays disabled, no reset

        // R9 status writes ignored, scratch
        wr(3'd5, 8'hFF, 0);
        wr(3'd6, 8'hFF, 0);
        wr(3'd7, 8'hA5, 0);
        check_all("R9");

        // random phase
        for (int i = 0; i < 600; i++) begin
            logic [2:0] a;
            logic [7:0] d;
            a = 3'($urandom_range(0, 7));
            d = 8'($urandom);
            if (a == 3'd3 && ($urandom_range(0, 1) == 0)) d[7] = 1'b0;
            wr(a, d, 1'($urandom_range(0, 1)));
            if ($urandom_range(0, 9) == 0) ack();
            if ($urandom_range(0, 9) == 0) sta_read();
            if (i % 30 == 0) check_all("R9 random");
        end
        check_all("R11 final");

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule